// File: doc/BRIEF.md
# Register-Programmed DMA Transfer Engine

This block moves a run of bytes between one peripheral and main memory so that the processor never handles the individual words. Software sets a start address, a byte count and a configuration word through four memory-mapped registers. The configuration word holds the beat size, the burst length, the direction and the number of the device to serve. A write to the control register then starts the transfer. From that point the engine runs on its own. It takes beats from the device and writes them to memory, or it reads beats from memory and hands them to the device. A level interrupt tells the processor that the last byte has moved.

Memory traffic goes over a single-outstanding request/grant port, and read data returns later on a valid strobe. The device side has a valid/ready pair for each direction. It also has a ready-to-receive input, which the engine checks before each outgoing burst. Beats are grouped into bursts of the programmed length. The final burst is shorter when fewer bytes remain.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, irq, mem_req, dev_in_ready and dev_out_valid are 0, and all four registers read 0.
- R2: Register select 0 holds the start address and select 1 holds the byte count. Select 2 holds the configuration: bits [1:0] unit code, bit 2 direction (1 = memory to device), bits [7:4] burst length minus one, bits [15:8] device number. Select 3 is control and status: a write of bit 0 starts a transfer and a write of bit 1 clears done; a read returns busy in bit 0 and done in bit 1.
- R3: While busy, writes to selects 0, 1 and 2 and a further start write have no effect.
- R4: Unit codes 0, 1 and 2 give 1, 2 and 4 byte beats; code 3 behaves as 4 bytes. Beat k is issued at start address + k × unit, with mem_size equal to the effective code.
- R5: A transfer of N bytes takes exactly ceil(N / unit) memory beats. The remaining count drops by the unit per beat and saturates at zero.
- R6: With B = burst field + 1, mem_last is 1 on beat k exactly when k mod B = B − 1 or k is the final beat.
- R7: In the device-to-memory direction, each word taken from the device is written to memory, in order, at the next beat address.
- R8: In the memory-to-device direction, the data read for each beat goes to the device in order. No burst issues its first memory read until dev_tx_rdy has been seen high since the previous burst ended.
- R9: irq rises in the same cycle that busy falls after the last beat. It then stays high until a control write with bit 1 or bit 0 set.
- R10: A start with a byte count of zero sets done on that clock edge and produces no memory or device traffic.
- R11: A memory request that is not granted stays asserted with the same address and direction in the next cycle.
- R12: dev_id carries the programmed device number throughout the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the beat |
| mem_size | output | 2 | log2 of the beat size in bytes |
| mem_last | output | 1 | Last beat of the burst |
| mem_wdata | output | 32 | Write data, low bytes significant |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| dev_id | output | 8 | Device number of the transfer |
| dev_tx_rdy | input | 1 | Device can take an outgoing burst |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_data | input | 32 | Word from the device |
| dev_in_ready | output | 1 | Engine takes the offered word |
| dev_out_valid | output | 1 | Engine offers a word |
| dev_out_data | output | 32 | Word to the device |
| dev_out_ready | input | 1 | Device takes the offered word |
| irq | output | 1 | Completion interrupt, level |

## Verification
A wrong beat address, size or remaining count shows up at the memory port on the very beat it occurs, as a wrong mem_addr, mem_size or mem_last. It also shows up at the end as a wrong beat total, a few cycles later. A wrong burst index appears on the first beat where mem_last should or should not be set. An early burst start in the outgoing direction appears as a memory read with no sighting of dev_tx_rdy since the last burst. The sweep varies direction, unit code, burst length and byte counts that are zero, below one unit and not multiples of the unit, so that each of these paths is exercised.

// File: rtl/dma_pkg.sv
package dma_pkg;
    parameter int DMA_BW   = 4;
    parameter int DMA_DEVW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_DEV_IN,
        ST_MEM_WR,
        ST_MEM_RD,
        ST_RD_WAIT,
        ST_DEV_OUT
    } dma_state_e;

    typedef struct packed {
        logic [DMA_DEVW-1:0] dev;
        logic [DMA_BW-1:0]   burst_m1;
        logic                to_dev;
        logic [1:0]          unit_lg;
    } dma_cfg_t;
endpackage

// File: rtl/dma_csr_file.sv
module dma_csr_file
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    input  logic          busy_i,
    input  logic          done_set_i,
    output logic [AW-1:0] base_o,
    output logic [CW-1:0] count_o,
    output dma_cfg_t      cfg_o,
    output logic          start_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] count;
        dma_cfg_t      cfg;
        logic          done;
    } csr_s;

    csr_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        start_o = reg_we && (reg_sel == 2'd3) && reg_wdata[0] && !busy_i;
        if (reg_we && !busy_i) begin
            case (reg_sel)
                2'd0: s_d.base  = reg_wdata[AW-1:0];
                2'd1: s_d.count = reg_wdata[CW-1:0];
                2'd2: begin
                    s_d.cfg.unit_lg  = reg_wdata[1:0];
                    s_d.cfg.to_dev   = reg_wdata[2];
                    s_d.cfg.burst_m1 = reg_wdata[4 +: DMA_BW];
                    s_d.cfg.dev      = reg_wdata[8 +: DMA_DEVW];
                end
                default: ;
            endcase
        end
        if (reg_we && (reg_sel == 2'd3) && (reg_wdata[1] || start_o))
            s_d.done = 1'b0;
        if (done_set_i)
            s_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        case (reg_sel)
            2'd0: rdata_o[AW-1:0] = s_q.base;
            2'd1: rdata_o[CW-1:0] = s_q.count;
            2'd2: begin
                rdata_o[1:0]           = s_q.cfg.unit_lg;
                rdata_o[2]             = s_q.cfg.to_dev;
                rdata_o[4 +: DMA_BW]   = s_q.cfg.burst_m1;
                rdata_o[8 +: DMA_DEVW] = s_q.cfg.dev;
            end
            default: begin
                rdata_o[0] = busy_i;
                rdata_o[1] = s_q.done;
            end
        endcase
    end

    assign base_o  = s_q.base;
    assign count_o = s_q.count;
    assign cfg_o   = s_q.cfg;
    assign done_o  = s_q.done;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       base_i,
    input  logic [CW-1:0]       count_i,
    input  dma_cfg_t            cfg_i,
    output logic                busy_o,
    output logic                done_set_o,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [1:0]          mem_size,
    output logic                mem_last,
    output logic [DW-1:0]       mem_wdata,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [DW-1:0]       mem_rdata,
    output logic [DMA_DEVW-1:0] dev_id,
    input  logic                dev_tx_rdy,
    input  logic                dev_in_valid,
    input  logic [DW-1:0]       dev_in_data,
    output logic                dev_in_ready,
    output logic                dev_out_valid,
    output logic [DW-1:0]       dev_out_data,
    input  logic                dev_out_ready
);
    localparam int MAX_LG = $clog2(DW / 8);

    typedef struct packed {
        dma_state_e          st;
        logic [AW-1:0]       addr;
        logic [CW-1:0]       remain;
        logic [DMA_BW-1:0]   beat;
        logic [DW-1:0]       data;
        dma_cfg_t            cfg;
    } fsm_s;

    fsm_s s_d, s_q;

    logic [1:0]    lg_eff;
    logic [CW-1:0] unit_b;
    logic          final_beat;
    logic          burst_end;
    logic          beat_done;

    always_comb begin
        lg_eff     = (s_q.cfg.unit_lg > 2'(MAX_LG)) ? 2'(MAX_LG) : s_q.cfg.unit_lg;
        unit_b     = CW'(1) << lg_eff;
        final_beat = (s_q.remain <= unit_b);
        burst_end  = (s_q.beat == s_q.cfg.burst_m1) || final_beat;
    end

    always_comb begin
        s_d           = s_q;
        done_set_o    = 1'b0;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        dev_in_ready  = 1'b0;
        dev_out_valid = 1'b0;
        beat_done     = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (count_i == '0) begin
                        done_set_o = 1'b1;
                    end else begin
                        s_d.st     = ST_ARM;
                        s_d.addr   = base_i;
                        s_d.remain = count_i;
                        s_d.beat   = '0;
                        s_d.cfg    = cfg_i;
                    end
                end
            end
            ST_ARM: begin
                if (!s_q.cfg.to_dev)  s_d.st = ST_DEV_IN;
                else if (dev_tx_rdy)  s_d.st = ST_MEM_RD;
            end
            ST_DEV_IN: begin
                dev_in_ready = 1'b1;
                if (dev_in_valid) begin
                    s_d.data = dev_in_data;
                    s_d.st   = ST_MEM_WR;
                end
            end
            ST_MEM_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                beat_done = mem_gnt;
            end
            ST_MEM_RD: begin
                mem_req = 1'b1;
                if (mem_gnt) s_d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rvalid) begin
                    s_d.data = mem_rdata;
                    s_d.st   = ST_DEV_OUT;
                end
            end
            ST_DEV_OUT: begin
                dev_out_valid = 1'b1;
                beat_done     = dev_out_ready;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (beat_done) begin
            s_d.addr   = s_q.addr + AW'(unit_b);
            s_d.remain = final_beat ? '0 : (s_q.remain - unit_b);
            s_d.beat   = burst_end ? '0 : (s_q.beat + 1'b1);
            if (final_beat) begin
                s_d.st     = ST_IDLE;
                done_set_o = 1'b1;
            end else if (burst_end) begin
                s_d.st = ST_ARM;
            end else begin
                s_d.st = s_q.cfg.to_dev ? ST_MEM_RD : ST_DEV_IN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o       = (s_q.st != ST_IDLE);
    assign mem_addr     = s_q.addr;
    assign mem_size     = lg_eff;
    assign mem_last     = burst_end;
    assign mem_wdata    = s_q.data;
    assign dev_out_data = s_q.data;
    assign dev_id       = s_q.cfg.dev;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_we,
    input  logic [1:0]          csr_addr,
    input  logic [DW-1:0]       csr_wdata,
    output logic [DW-1:0]       csr_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [1:0]          mem_size,
    output logic                mem_last,
    output logic [DW-1:0]       mem_wdata,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [DW-1:0]       mem_rdata,
    output logic [DMA_DEVW-1:0] dev_id,
    input  logic                dev_tx_rdy,
    input  logic                dev_in_valid,
    input  logic [DW-1:0]       dev_in_data,
    output logic                dev_in_ready,
    output logic                dev_out_valid,
    output logic [DW-1:0]       dev_out_data,
    input  logic                dev_out_ready,
    output logic                irq
);
    logic          xfer_busy;
    logic          done_set;
    logic          start_w;
    logic          done_w;
    logic [AW-1:0] base_w;
    logic [CW-1:0] count_w;
    dma_cfg_t      cfg_w;

    dma_csr_file #(.AW(AW), .CW(CW), .DW(DW)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (csr_we),
        .reg_sel    (csr_addr),
        .reg_wdata  (csr_wdata),
        .busy_i     (xfer_busy),
        .done_set_i (done_set),
        .base_o     (base_w),
        .count_o    (count_w),
        .cfg_o      (cfg_w),
        .start_o    (start_w),
        .done_o     (done_w),
        .rdata_o    (csr_rdata)
    );

    dma_xfer_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_w),
        .base_i        (base_w),
        .count_i       (count_w),
        .cfg_i         (cfg_w),
        .busy_o        (xfer_busy),
        .done_set_o    (done_set),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_size      (mem_size),
        .mem_last      (mem_last),
        .mem_wdata     (mem_wdata),
        .mem_gnt       (mem_gnt),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .dev_id        (dev_id),
        .dev_tx_rdy    (dev_tx_rdy),
        .dev_in_valid  (dev_in_valid),
        .dev_in_data   (dev_in_data),
        .dev_in_ready  (dev_in_ready),
        .dev_out_valid (dev_out_valid),
        .dev_out_data  (dev_out_data),
        .dev_out_ready (dev_out_ready)
    );

    assign irq = done_w;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          csr_we,
    input logic [1:0]    csr_addr,
    input logic [DW-1:0] csr_wdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_gnt,
    input logic          dev_in_ready,
    input logic          dev_out_valid,
    input logic          irq,
    input logic          busy,
    input dma_cfg_t      cfg
);
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(csr_we && csr_addr == 2'd3 && (csr_wdata[1] || csr_wdata[0])) |=> irq);

    a_r9_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy);

    a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy && csr_we && csr_addr == 2'd2 |=> $stable(cfg));

    a_r10_no_traffic_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !dev_in_ready && !dev_out_valid);

    a_r7_one_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, dev_in_ready, dev_out_valid}));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_we        (csr_we),
    .csr_addr      (csr_addr),
    .csr_wdata     (csr_wdata),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_gnt       (mem_gnt),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .irq           (irq),
    .busy          (xfer_busy),
    .cfg           (cfg_w)
);

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mem_req, mem_we, mem_last;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  dev_id;
    logic        dev_tx_rdy = 1'b0, dev_in_valid = 1'b0, dev_out_ready = 1'b0;
    logic [31:0] dev_in_data = '0;
    logic        dev_in_ready, dev_out_valid;
    logic [31:0] dev_out_data;
    logic        irq;

    always #10 clk = ~clk;

    dma_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_last(mem_last), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .dev_id(dev_id),
        .dev_tx_rdy(dev_tx_rdy), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .irq(irq)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // current transfer expectations
    logic [31:0] cur_base;
    int cur_u = 1, cur_b = 1, cur_beats = 0, cur_lg = 0;
    logic [7:0] cur_dev;
    int k_mem, k_in, k_out;
    bit rdy_seen;
    bit rd_due;
    logic [31:0] rd_addr;
    bit prev_stall;
    logic [31:0] prev_addr;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mword(input logic [31:0] a);
        for (int i = 0; i < 4; i++) mword[8*i +: 8] = 8'(a + 32'(i)) ^ 8'h5A;
    endfunction

    function automatic logic [31:0] iword(input int k);
        for (int i = 0; i < 4; i++) iword[8*i +: 8] = 8'(4*k + i) ^ 8'h3C;
    endfunction

    function automatic logic [31:0] umask(input int u);
        umask = (u == 1) ? 32'hFF : (u == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    // memory and device models plus beat monitor, driven away from posedge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            mem_gnt       = mem_req && (cyc % 2 == 1);
            mem_rvalid    = rd_due;
            mem_rdata     = rd_due ? mword(rd_addr) : '0;
            rd_due        = 0;
            dev_in_valid  = (cyc % 3 != 1);
            dev_in_data   = iword(k_in);
            dev_out_ready = (cyc % 3 != 0);
            dev_tx_rdy    = (cyc % 4 == 3);
            #5;
            if (rst_n) begin
                if (prev_stall)
                    chk(mem_req && mem_addr == prev_addr, "R11 held request", mem_addr, prev_addr);
                prev_stall = mem_req && !mem_gnt;
                prev_addr  = mem_addr;
                if (mem_req && mem_gnt) begin
                    chk(mem_addr == cur_base + 32'(k_mem * cur_u), "R4 beat address", mem_addr, cur_base + 32'(k_mem * cur_u));
                    chk(mem_size == 2'(cur_lg), "R4 beat size", 32'(mem_size), 32'(cur_lg));
                    chk(mem_last == (((k_mem % cur_b) == cur_b - 1) || (k_mem == cur_beats - 1)),
                        "R6 burst last", 32'(mem_last), 32'(k_mem));
                    chk(dev_id == cur_dev, "R12 device number", 32'(dev_id), 32'(cur_dev));
                    if (mem_we) begin
                        chk((mem_wdata & umask(cur_u)) == (iword(k_mem) & umask(cur_u)),
                            "R7 written data", mem_wdata, iword(k_mem));
                    end else begin
                        rd_due  = 1;
                        rd_addr = mem_addr;
                        if (k_mem % cur_b == 0)
                            chk(rdy_seen, "R8 burst waits for device ready", 32'(rdy_seen), 32'd1);
                    end
                    k_mem++;
                end
                if (dev_tx_rdy) rdy_seen = 1;
                if (dev_in_valid && dev_in_ready) k_in++;
                if (dev_out_valid && dev_out_ready) begin
                    chk((dev_out_data & umask(cur_u)) == (mword(cur_base + 32'(k_out * cur_u)) & umask(cur_u)),
                        "R8 data to device", dev_out_data, mword(cur_base + 32'(k_out * cur_u)));
                    if ((k_out % cur_b) == cur_b - 1) rdy_seen = 0;
                    k_out++;
                end
            end
        end
    end

    task automatic csr_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = sel; csr_wdata = val;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic csr_read(input logic [1:0] sel, output logic [31:0] val);
        @(negedge clk);
        csr_addr = sel;
        #5;
        val = csr_rdata;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    endtask

    task automatic setup(input bit dir, input int lg, input int bm1, input int n, input logic [7:0] dev,
                         input logic [31:0] base);
        cur_base  = base;
        cur_lg    = (lg > 2) ? 2 : lg;
        cur_u     = 1 << cur_lg;
        cur_b     = bm1 + 1;
        cur_beats = (n + cur_u - 1) / cur_u;
        cur_dev   = dev;
        k_mem = 0; k_in = 0; k_out = 0;
        csr_write(2'd0, base);
        csr_write(2'd1, 32'(n));
        csr_write(2'd2, {16'd0, dev, 4'(bm1), 1'b0, dir, 2'(lg)});
    endtask

    task automatic run_xfer(input bit dir, input int lg, input int bm1, input int n, input logic [7:0] dev,
                            input logic [31:0] base);
        logic [31:0] st;
        setup(dir, lg, bm1, n, dev, base);
        csr_write(2'd3, 32'd1);
        rdy_seen = 0;
        if (n == 0) begin
            chk(irq == 1'b1, "R10 zero count done at once", 32'(irq), 32'd1);
        end
        wait_irq();
        chk(irq == 1'b1, "R9 irq at completion", 32'(irq), 32'd1);
        chk(k_mem == cur_beats, "R5 beat total", 32'(k_mem), 32'(cur_beats));
        if (n == 0) chk(k_in == 0 && k_out == 0, "R10 no device traffic", 32'(k_in + k_out), 32'd0);
        csr_read(2'd3, st);
        chk(st[1:0] == 2'b10, "R2 status done not busy", st, 32'd2);
        csr_write(2'd3, 32'd2);
        chk(irq == 1'b0, "R9 done cleared by write", 32'(irq), 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        int t;
        repeat (3) @(negedge clk);
        #5;
        chk(irq == 0 && mem_req == 0 && dev_in_ready == 0 && dev_out_valid == 0,
            "R1 reset outputs", {irq, mem_req, dev_in_ready, dev_out_valid}, 32'd0);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            csr_read(2'(s), v);
            chk(v == 0, "R1 reset register", v, 32'd0);
        end

        // register readback
        csr_write(2'd0, 32'h0000_1234);
        csr_read(2'd0, v);
        chk(v == 32'h1234, "R2 address register", v, 32'h1234);
        csr_write(2'd2, 32'h0000_A5F6);
        csr_read(2'd2, v);
        chk(v == 32'h0000_A5F6, "R2 config register", v, 32'h0000_A5F6);

        // irq holds with no clear write
        run_xfer(1'b0, 2, 1, 8, 8'h11, 32'h0000_0100);
        setup(1'b0, 0, 0, 1, 8'h22, 32'h0000_0180);
        csr_write(2'd3, 32'd1);
        rdy_seen = 0;
        wait_irq();
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R9 irq stays high", 32'(irq), 32'd1);
        csr_write(2'd3, 32'd2);

        // writes while busy are ignored
        setup(1'b1, 0, 0, 16, 8'h5C, 32'h0000_0300);
        csr_write(2'd3, 32'd1);
        rdy_seen = 0;
        csr_write(2'd2, 32'h0000_FFFF);
        csr_write(2'd0, 32'h0000_DEAD);
        csr_write(2'd1, 32'd3);
        csr_write(2'd3, 32'd1);
        csr_read(2'd2, v);
        chk(v == 32'h0000_5C04, "R3 config unchanged while busy", v, 32'h0000_5C04);
        csr_read(2'd0, v);
        chk(v == 32'h0000_0300, "R3 address unchanged while busy", v, 32'h300);
        csr_read(2'd1, v);
        chk(v == 32'd16, "R3 count unchanged while busy", v, 32'd16);
        csr_read(2'd3, v);
        chk(v[0] == 1'b1, "R2 busy bit during transfer", v, 32'd1);
        wait_irq();
        chk(k_mem == 16, "R3 transfer runs to original count", 32'(k_mem), 32'd16);
        csr_write(2'd3, 32'd2);

        // sweep
        t = 0;
        for (int dir = 0; dir < 2; dir++)
            for (int lg = 0; lg < 4; lg++)
                for (int bi = 0; bi < 3; bi++)
                    for (int ni = 0; ni < 5; ni++) begin
                        int bm1;
                        int n;
                        bm1 = (bi == 0) ? 0 : (bi == 1) ? 2 : 3;
                        n   = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 5 : (ni == 3) ? 8 : 13;
                        run_xfer(dir[0], lg, bm1, n, 8'(t + 1), 32'h0000_0400 + 32'(t * 64));
                        t++;
                    end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule